// File: doc/BRIEF.md
# Privileged-Mode Banked Integer Register File

This block holds the integer register state of a 64-bit core: 32 architectural register numbers backed by 31 storage rows, plus a separate bank of eight alternate rows. When the core enters its privileged mode, a fixed set of architectural register numbers is redirected to the alternate bank. Privileged code can then use those registers as scratch space without first saving the user's values. The redirected numbers do not form one contiguous run. They are the seven numbers 8 to 14 and the single number 25.

The file has two combinational read ports and one write port that updates on the clock edge. All three ports apply the same mode-dependent remapping, so a write and a later read of the same register number in the same mode always reach the same row. Register 31 is a constant zero. Reset is synchronous and active-low, and it clears every stored row.

Top module: `banked_regfile`

## Requirements
- R1: With `pal_mode` high, register numbers 8, 9, 10, 11, 12, 13 and 14 address alternate rows 0 to 6 respectively.
- R2: With `pal_mode` high, register number 25 addresses alternate row 7.
- R3: With `pal_mode` low, every register number 0 to 30 addresses its own normal row. With `pal_mode` high, every number other than 8 to 14 and 25 also addresses its normal row.
- R4: The write port and both read ports use the same mapping. A value written to register 9 with `pal_mode` high reads back with `pal_mode` high, and register 9 read with `pal_mode` low does not return it.
- R5: Register number 31 reads as zero on both ports in both modes, and a write to it changes no row.
- R6: A write takes effect at the rising clock edge only when `wr_en` is 1. With `wr_en` at 0, no row changes, whatever `wr_addr` and `wr_data` carry.
- R7: Reads are combinational from the stored rows. A read of the register being written in the same cycle returns the old value until the edge, and the new value after it.
- R8: A clock edge with `rst_n` low sets all 31 normal rows and all 8 alternate rows to zero.
- R9: The normal rows of registers 8 to 14 and 25 keep their values while `pal_mode` is high and become readable again once it falls.
- R10: The two read ports are independent. Each one returns the register its own address selects, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_mode | input | 1 | 1 selects the privileged mapping |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register number to write |
| wr_data | input | 64 | Write data |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | 64 | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | 64 | Read port B data |

## Verification
The bench concentrates on the edges of the redirected set: numbers 7, 15, 24 and 26 next to numbers 8, 14 and 25. A decoder with an off-by-one range would alias one of these into the alternate bank, or would leave one of them out. It writes alternate rows and then leaves the privileged mode, to confirm that the user values survived. A write path that ignored the mode would overwrite them, and a read path that ignored the mode would show privileged data to user code. It also reads a register in the same cycle it is written, to catch a hidden bypass. It writes to register 31 and then reads it, to catch a zero register that is actually stored. The run ends with a long random phase in which the mode, the addresses and `wr_en` all change freely, compared every cycle against a behavioural model.

// File: rtl/banked_rf_pkg.sv
// Shared types for the banked register file.
// Assumes: nothing beyond IEEE 1800-2017.
package banked_rf_pkg;

    // Which storage a remapped register number lands in.
    typedef enum logic [1:0] {
        RT_MAIN   = 2'd0,
        RT_SHADOW = 2'd1,
        RT_ZERO   = 2'd2
    } rf_target_e;

endpackage

// File: rtl/rf_remap.sv
// Maps an architectural register number to a storage target and row.
// With pal_mode set, a run of RUN_LEN numbers starting at RUN_BASE goes to
// alternate rows 0..RUN_LEN-1, and EXTRA_REG goes to the last alternate row.
// The highest number is the constant-zero register.
// Assumes: RUN_LEN + 1 == SHADOW_REGS, and EXTRA_REG lies outside the run.
module rf_remap
    import banked_rf_pkg::*;
#(
    parameter int ARCH_REGS   = 32,
    parameter int SHADOW_REGS = 8,
    parameter int RUN_BASE    = 8,
    parameter int RUN_LEN     = 7,
    parameter int EXTRA_REG   = 25,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int SW = $clog2(SHADOW_REGS)
) (
    input  logic       pal_mode,
    input  logic [AW-1:0] arch_idx,
    output rf_target_e target,
    output logic [AW-1:0] main_idx,
    output logic [SW-1:0] shad_idx
);

    localparam int ZERO_REG = ARCH_REGS - 1;

    logic in_run;
    logic is_extra;

    // Classify the number against the redirected set.
    always_comb begin
        in_run   = (32'(arch_idx) >= RUN_BASE) && (32'(arch_idx) < RUN_BASE + RUN_LEN);
        is_extra = (32'(arch_idx) == EXTRA_REG);
    end

    // Select target and row index.
    always_comb begin
        main_idx = arch_idx;
        shad_idx = '0;
        target   = RT_MAIN;
        if (32'(arch_idx) == ZERO_REG) begin
            target = RT_ZERO;
        end else if (pal_mode && in_run) begin
            target   = RT_SHADOW;
            shad_idx = SW'(32'(arch_idx) - RUN_BASE);
        end else if (pal_mode && is_extra) begin
            target   = RT_SHADOW;
            shad_idx = SW'(SHADOW_REGS - 1);
        end
    end

    // R3: the alternate bank is never chosen outside the privileged mode.
    always_comb begin
        p_shadow_in_pal_r3: assert (target != RT_SHADOW || pal_mode);
    end

endmodule

// File: rtl/rf_store.sv
// Flop-based storage rows with one write port and two combinational reads.
// An index at or above DEPTH reads zero.
// Reset is synchronous and active-low and clears every row.
// Assumes: the caller gates the write enable; there is no write-to-read bypass.
module rf_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IW-1:0]     ridx_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IW-1:0]     ridx_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DEPTH-1:0][DATA_W-1:0] mem;

    // Row update: clear on reset, else write the addressed row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we && 32'(widx) == i) begin
                    mem[i] <= wdata;
                end
            end
        end
    end

    // Combinational read of both ports, zero when out of range.
    always_comb begin
        rdata_a = (32'(ridx_a) < DEPTH) ? mem[ridx_a] : '0;
        rdata_b = (32'(ridx_b) < DEPTH) ? mem[ridx_b] : '0;
    end

    // R6: an idle write port leaves every row untouched.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));

    // R6: an enabled write lands in its row at the edge.
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && 32'(widx) < DEPTH) |=> mem[$past(widx)] == $past(wdata));

endmodule

// File: rtl/banked_regfile.sv
// Integer register file with an alternate bank for privileged mode.
// Three remap instances (one write, two read) share one mapping rule.
// They steer each access to the normal rows, the alternate rows or the
// constant zero.
// Assumes: pal_mode is stable around the clock edge like any other input.
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int ARCH_REGS   = 32,
    parameter int SHADOW_REGS = 8,
    parameter int RUN_BASE    = 8,
    parameter int EXTRA_REG   = 25,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int SW = $clog2(SHADOW_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_mode,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);

    localparam int NUM_RD     = 2;
    localparam int MAIN_DEPTH = ARCH_REGS - 1;
    localparam int RUN_LEN    = SHADOW_REGS - 1;

    rf_target_e       wr_tgt;
    logic [AW-1:0]    wr_midx;
    logic [SW-1:0]    wr_sidx;
    logic             main_we;
    logic             shad_we;

    logic [AW-1:0]     rd_addr [NUM_RD];
    rf_target_e        rd_tgt  [NUM_RD];
    logic [AW-1:0]     rd_midx [NUM_RD];
    logic [SW-1:0]     rd_sidx [NUM_RD];
    logic [DATA_W-1:0] main_q  [NUM_RD];
    logic [DATA_W-1:0] shad_q  [NUM_RD];
    logic [DATA_W-1:0] rd_q    [NUM_RD];

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;
    assign rd_a_data  = rd_q[0];
    assign rd_b_data  = rd_q[1];

    // Write-side mapping.
    rf_remap #(
        .ARCH_REGS(ARCH_REGS), .SHADOW_REGS(SHADOW_REGS),
        .RUN_BASE(RUN_BASE), .RUN_LEN(RUN_LEN), .EXTRA_REG(EXTRA_REG)
    ) u_wr_map (
        .pal_mode(pal_mode), .arch_idx(wr_addr),
        .target(wr_tgt), .main_idx(wr_midx), .shad_idx(wr_sidx)
    );

    // Gate the write into exactly one bank; the zero register gets none.
    always_comb begin
        main_we = wr_en && (wr_tgt == RT_MAIN);
        shad_we = wr_en && (wr_tgt == RT_SHADOW);
    end

    // Per-port read mapping and output selection.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_remap #(
            .ARCH_REGS(ARCH_REGS), .SHADOW_REGS(SHADOW_REGS),
            .RUN_BASE(RUN_BASE), .RUN_LEN(RUN_LEN), .EXTRA_REG(EXTRA_REG)
        ) u_rd_map (
            .pal_mode(pal_mode), .arch_idx(rd_addr[p]),
            .target(rd_tgt[p]), .main_idx(rd_midx[p]), .shad_idx(rd_sidx[p])
        );

        // Pick the bank the mapping named for this port.
        always_comb begin
            unique case (rd_tgt[p])
                RT_MAIN:   rd_q[p] = main_q[p];
                RT_SHADOW: rd_q[p] = shad_q[p];
                default:   rd_q[p] = '0;
            endcase
        end
    end

    // Normal rows 0..ARCH_REGS-2.
    rf_store #(.DEPTH(MAIN_DEPTH), .DATA_W(DATA_W)) u_main (
        .clk(clk), .rst_n(rst_n),
        .we(main_we), .widx(wr_midx), .wdata(wr_data),
        .ridx_a(rd_midx[0]), .rdata_a(main_q[0]),
        .ridx_b(rd_midx[1]), .rdata_b(main_q[1])
    );

    // Alternate rows for the privileged mode.
    rf_store #(.DEPTH(SHADOW_REGS), .DATA_W(DATA_W)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .we(shad_we), .widx(wr_sidx), .wdata(wr_data),
        .ridx_a(rd_sidx[0]), .rdata_a(shad_q[0]),
        .ridx_b(rd_sidx[1]), .rdata_b(shad_q[1])
    );

    // R5: the zero register reads zero on port A.
    p_zero_read_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_a_addr) == ARCH_REGS - 1) |-> rd_a_data == '0);

    // R5: the zero register reads zero on port B.
    p_zero_read_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_b_addr) == ARCH_REGS - 1) |-> rd_b_data == '0);

    // R4: a write is read back through the same number in the same mode.
    p_same_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 32'(wr_addr) != ARCH_REGS - 1) |=>
        (!(rd_a_addr == $past(wr_addr) && pal_mode == $past(pal_mode))
         || rd_a_data == $past(wr_data)));

endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_a_addr = '0;
    logic [63:0] rd_a_data;
    logic [4:0]  rd_b_addr = '0;
    logic [63:0] rd_b_data;

    int checks = 0;
    int errors = 0;

    logic [63:0] ref_nm [0:30];
    logic [63:0] ref_sh [0:7];

    always #5 clk = ~clk;

    banked_regfile u0 (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    // Behavioural model of one read.
    function automatic logic [63:0] exp_read(logic pal, int a);
        if (a == 31) return 64'd0;
        if (pal && a >= 8 && a <= 14) return ref_sh[a - 8];
        if (pal && a == 25) return ref_sh[7];
        return ref_nm[a];
    endfunction

    task automatic model_write(logic pal, int a, logic [63:0] d);
        if (a == 31) return;
        if (pal && a >= 8 && a <= 14) ref_sh[a - 8] = d;
        else if (pal && a == 25) ref_sh[7] = d;
        else ref_nm[a] = d;
    endtask

    task automatic model_clear();
        for (int i = 0; i < 31; i++) ref_nm[i] = '0;
        for (int i = 0; i < 8; i++) ref_sh[i] = '0;
    endtask

    task automatic chk(string tag, string what, int a, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s reg %0d pal %0b: got %h expected %h",
                     tag, what, a, pal_mode, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // One clock: drive at negedge, compare pre-edge, update model after edge.
    task automatic step(logic rn, logic pal, logic we, int wa, logic [63:0] wd,
                        int ra, int rb, string tag);
        @(negedge clk);
        rst_n = rn; pal_mode = pal; wr_en = we;
        wr_addr = 5'(wa); wr_data = wd; rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
        #1;
        if (rn) begin
            chk(tag, "portA", ra, rd_a_data, exp_read(pal, ra));
            chk(tag, "portB", rb, rd_b_data, exp_read(pal, rb));
        end
        @(posedge clk);
        #1;
        if (!rn) model_clear();
        else if (we) model_write(pal, wa, wd);
    endtask

    function automatic logic [63:0] nval(int i);
        return 64'hA5A5_0000_0000_0000 | 64'(i * 3 + 1);
    endfunction

    function automatic logic [63:0] sval(int i);
        return 64'h5A5A_F000_0000_0000 | 64'(i * 7 + 2);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL WATCHDOG: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        model_clear();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 0, '0, 0, 0, "R8");
        // R8: after reset every register reads zero in both modes.
        for (int i = 0; i < 32; i++) step(1'b1, i[0], 1'b0, 0, '1, i, 31 - i, "R8");

        // R3/R6: user-mode writes to every number, including 31 (R5).
        for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 1'b1, i, nval(i), 30 - (i % 31), 7, "R3");
        step(1'b1, 1'b0, 1'b0, 0, '0, 31, 31, "R5");
        // R10: two ports on different registers.
        for (int i = 0; i < 31; i++) step(1'b1, 1'b0, 1'b0, 0, '0, i, 30 - i, "R10");

        // R1/R2: fresh alternate rows read zero; boundaries read normal rows (R3).
        for (int i = 6; i < 17; i++) step(1'b1, 1'b1, 1'b0, 0, '0, i, 25, "R1");
        step(1'b1, 1'b1, 1'b0, 0, '0, 24, 26, "R2");
        step(1'b1, 1'b1, 1'b0, 0, '0, 25, 7, "R2");

        // R4: privileged writes to the redirected numbers, read back.
        for (int i = 8; i <= 14; i++) step(1'b1, 1'b1, 1'b1, i, sval(i), i, 15, "R1");
        step(1'b1, 1'b1, 1'b1, 25, sval(25), 25, 24, "R2");
        for (int i = 8; i <= 14; i++) step(1'b1, 1'b1, 1'b0, 0, '0, i, 25, "R4");
        step(1'b1, 1'b1, 1'b1, 31, '1, 31, 30, "R5");
        step(1'b1, 1'b1, 1'b0, 0, '0, 31, 25, "R5");

        // R7: read the register being written; old value before, new after.
        step(1'b1, 1'b1, 1'b1, 9, 64'hDEAD_BEEF_0000_0009, 9, 9, "R7");
        step(1'b1, 1'b1, 1'b0, 9, 64'h1111, 9, 9, "R7");
        step(1'b1, 1'b0, 1'b1, 3, 64'hCAFE_0003, 3, 9, "R7");
        step(1'b1, 1'b0, 1'b0, 3, '0, 3, 9, "R7");

        // R6: disabled writes with live data change nothing.
        for (int i = 0; i < 32; i++) step(1'b1, i[1], 1'b0, i, 64'hBAD0_0000 | 64'(i), i, (i + 5) % 32, "R6");
        for (int i = 0; i < 31; i++) step(1'b1, 1'b0, 1'b0, 0, '0, i, i, "R6");

        // R9: normal rows of the redirected numbers survive privileged writes.
        for (int i = 8; i <= 14; i++) step(1'b1, 1'b0, 1'b0, 0, '0, i, 25, "R9");
        step(1'b1, 1'b1, 1'b0, 0, '0, 25, 9, "R9");
        step(1'b1, 1'b0, 1'b0, 0, '0, 25, 9, "R9");

        // Random phase: mode, addresses and enable all vary (R4, R10).
        for (int i = 0; i < 400; i++)
            step(1'b1, 1'($urandom), 1'($urandom), int'($urandom % 32),
                 {$urandom, $urandom}, int'($urandom % 32), int'($urandom % 32), "R4");

        // R8: reset after traffic clears everything again.
        step(1'b0, 1'b0, 1'b1, 5, '1, 0, 0, "R8");
        for (int i = 0; i < 32; i++) step(1'b1, 1'b1, 1'b0, 0, '0, i, i, "R8");
        for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 1'b0, 0, '0, i, i, "R8");

        summary();
        $finish;
    end

endmodule